// File: doc/BRIEF.md
# Dual Compare-Match Timer Output

An 8-bit up-counter that advances on a count-enable tick, paired with two compare registers and a combined control/status register, all reachable by a processor over a small register bus. The block raises a status flag when the counter reaches either compare value and another when the counter rolls over from its top value to zero. It also drives one timer output pin whose level reacts to compare-match events according to four programmable action bits.

A flag can be cleared only in two steps: the processor reads the status register while the flag is set, and later writes zero to that flag's bit. Writing zero without that read, or writing one, leaves the flag as it is. When both comparators match in the same cycle and ask for different pin actions, the block applies a fixed precedence between the actions.

Top module: `cmt_timer`

## Requirements
- R1: After reset the counter and both compare registers read 0x00, the status register reads 0x10, and both the timer output and its enable are 0.
- R2: Register select codes are 0 counter, 1 compare A, 2 compare B, 3 control/status. The counter advances by one on each cycle with the tick high and wraps from 0xFF to 0x00. A bus write to the counter loads it and takes precedence over a tick in the same cycle.
- R3: Status bit 6 is set on the edge where the counter takes a new value equal to compare A, and bit 7 likewise for compare B. Writing a compare register with the counter's present value sets no flag.
- R4: Status bit 5 is set on the edge where a tick moves the counter from 0xFF to 0x00.
- R5: A flag clears only if a status read (read strobe with select 3) saw it at 1 and a later status write carries 0 in its bit. Any status write consumes that pending read. A status write of 1 never sets a flag.
- R6: If a flag's set condition occurs in the same cycle as a write that would clear it, the flag stays 1.
- R7: Status bit 4 always reads 1 and ignores writes; bits 3:0 read back what was last written.
- R8: Bits 1:0 select the pin action on a compare A match and bits 3:2 the action on a compare B match, encoded 00 keep, 01 drive 0, 10 drive 1, 11 invert. With no match the pin level does not change.
- R9: When both comparators match in the same cycle, inversion has precedence over drive 1, which has precedence over drive 0.
- R10: The output enable is 1 exactly when any of bits 3:0 is 1; with it at 0 the timer output is 0. After reset the output stays 0 until the first compare match.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count enable, one increment per cycle high |
| sel_i | input | 2 | Register select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the selected register |
| tmr_out_o | output | 1 | Timer output level |
| tmr_oe_o | output | 1 | Timer output enable |

## Verification
The assertions watch, on every cycle, that the counter steps by exactly one on a plain tick and lands on zero after a rollover, that a hardware set always wins over a clearing write, that a flag that was never read cannot disappear, and that the pin level holds without a match and obeys the inversion and drive-1 precedence. Only the bench scenarios can show the full read-then-write clearing sequence, that a compare write equal to the counter raises nothing, the reset values seen on the bus, and the resulting pin level for every one of the sixteen action pairs from both starting levels.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
    localparam int DW      = 8;
    localparam int NFLG    = 3;
    localparam int FLG_LSB = 5;
    localparam int OSW     = 4;

    localparam logic [1:0] SEL_CNT  = 2'd0;
    localparam logic [1:0] SEL_CMPA = 2'd1;
    localparam logic [1:0] SEL_CMPB = 2'd2;
    localparam logic [1:0] SEL_CSR  = 2'd3;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_INV  = 2'b11
    } act_e;

    // Merge two simultaneous actions: invert, then drive 1, then drive 0.
    function automatic act_e merge_act(input act_e a, input act_e b);
        if (a == ACT_INV || b == ACT_INV)
            return ACT_INV;
        else if (a == ACT_HIGH || b == ACT_HIGH)
            return ACT_HIGH;
        else if (a == ACT_LOW || b == ACT_LOW)
            return ACT_LOW;
        else
            return ACT_KEEP;
    endfunction
endpackage

// File: rtl/cmt_counter.sv
module cmt_counter
    import cmt_pkg::*;
#(
    parameter int W = DW
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         wr_i,
    input  logic [1:0]   sel_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] cmpa_o,
    output logic [W-1:0] cmpb_o,
    output logic         hit_a_o,
    output logic         hit_b_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] TOP = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] cmpa;
        logic [W-1:0] cmpb;
    } cnt_regs_t;

    cnt_regs_t cr_d, cr_q;
    logic      load_cnt;
    logic      moved;

    always_comb begin
        cr_d     = cr_q;
        load_cnt = wr_i && (sel_i == SEL_CNT);
        wrap_o   = 1'b0;
        if (load_cnt) begin
            cr_d.cnt = wdata_i;
        end else if (tick_i) begin
            cr_d.cnt = cr_q.cnt + ONE;
            wrap_o   = (cr_q.cnt == TOP);
        end
        if (wr_i && sel_i == SEL_CMPA) cr_d.cmpa = wdata_i;
        if (wr_i && sel_i == SEL_CMPB) cr_d.cmpb = wdata_i;
        moved   = (cr_d.cnt != cr_q.cnt);
        hit_a_o = moved && (cr_d.cnt == cr_q.cmpa);
        hit_b_o = moved && (cr_d.cnt == cr_q.cmpb);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cr_q <= '0;
        else        cr_q <= cr_d;
    end

    assign cnt_o  = cr_q.cnt;
    assign cmpa_o = cr_q.cmpa;
    assign cmpb_o = cr_q.cmpb;

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_cnt) |=> (cr_q.cnt == $past(cr_q.cnt) + ONE));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (cr_q.cnt == '0));
endmodule

// File: rtl/cmt_csr.sv
module cmt_csr
    import cmt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_i,
    input  logic            wr_i,
    input  logic [1:0]      sel_i,
    input  logic [NFLG-1:0] clr_bits_i,
    input  logic [OSW-1:0]  os_wdata_i,
    input  logic [NFLG-1:0] evt_i,
    output logic [NFLG-1:0] flg_o,
    output logic [OSW-1:0]  os_o
);
    typedef struct packed {
        logic [NFLG-1:0] flg;
        logic [NFLG-1:0] arm;
        logic [OSW-1:0]  os;
    } csr_regs_t;

    csr_regs_t cs_d, cs_q;
    logic      csr_rd, csr_wr;

    always_comb begin
        cs_d   = cs_q;
        csr_rd = rd_i && (sel_i == SEL_CSR);
        csr_wr = wr_i && (sel_i == SEL_CSR);
        for (int i = 0; i < NFLG; i++) begin
            if (csr_rd && cs_q.flg[i]) cs_d.arm[i] = 1'b1;
            if (csr_wr) begin
                if (cs_q.arm[i] && !clr_bits_i[i]) cs_d.flg[i] = 1'b0;
                cs_d.arm[i] = 1'b0;
            end
            if (evt_i[i]) cs_d.flg[i] = 1'b1;
        end
        if (csr_wr) cs_d.os = os_wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign flg_o = cs_q.flg;
    assign os_o  = cs_q.os;

    for (genvar g = 0; g < NFLG; g++) begin : g_flag_chk
        assert_hw_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> cs_q.flg[g]);
        assert_no_soft_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt_i[g] && !cs_q.flg[g]) |=> !cs_q.flg[g]);
        assert_clear_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cs_q.flg[g] && !cs_q.arm[g]) |=> cs_q.flg[g]);
    end
endmodule

// File: rtl/cmt_outlvl.sv
module cmt_outlvl
    import cmt_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hit_a_i,
    input  logic           hit_b_i,
    input  logic [OSW-1:0] os_i,
    output logic           tmr_o,
    output logic           oe_o
);
    typedef struct packed {
        logic lvl;
    } lvl_regs_t;

    lvl_regs_t lv_d, lv_q;
    act_e      act_a, act_b, act_win;

    always_comb begin
        lv_d    = lv_q;
        act_a   = hit_a_i ? act_e'(os_i[1:0]) : ACT_KEEP;
        act_b   = hit_b_i ? act_e'(os_i[3:2]) : ACT_KEEP;
        act_win = merge_act(act_a, act_b);
        case (act_win)
            ACT_LOW:  lv_d.lvl = 1'b0;
            ACT_HIGH: lv_d.lvl = 1'b1;
            ACT_INV:  lv_d.lvl = !lv_q.lvl;
            default:  lv_d.lvl = lv_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lv_q <= '0;
        else        lv_q <= lv_d;
    end

    assign oe_o  = |os_i;
    assign tmr_o = lv_q.lvl && oe_o;

    assert_hold_no_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_a_i || hit_b_i) |=> $stable(lv_q.lvl));

    assert_invert_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_a_i && os_i[1:0] == 2'b11) || (hit_b_i && os_i[3:2] == 2'b11))
        |=> (lv_q.lvl != $past(lv_q.lvl)));

    assert_high_beats_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_a_i && os_i[1:0] == 2'b10) || (hit_b_i && os_i[3:2] == 2'b10))
        && !(hit_a_i && os_i[1:0] == 2'b11) && !(hit_b_i && os_i[3:2] == 2'b11)
        |=> lv_q.lvl);
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
    import cmt_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [1:0]    sel_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          tmr_out_o,
    output logic          tmr_oe_o
);
    logic [DW-1:0]   cnt, cmpa, cmpb;
    logic            hit_a, hit_b, wrap;
    logic [NFLG-1:0] flg;
    logic [OSW-1:0]  os;

    cmt_counter #(.W(DW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .wr_i    (wr_i),
        .sel_i   (sel_i),
        .wdata_i (wdata_i),
        .cnt_o   (cnt),
        .cmpa_o  (cmpa),
        .cmpb_o  (cmpb),
        .hit_a_o (hit_a),
        .hit_b_o (hit_b),
        .wrap_o  (wrap)
    );

    // Flag order matches status bits 5..7: rollover, match A, match B.
    cmt_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_i       (rd_i),
        .wr_i       (wr_i),
        .sel_i      (sel_i),
        .clr_bits_i (wdata_i[FLG_LSB +: NFLG]),
        .os_wdata_i (wdata_i[OSW-1:0]),
        .evt_i      ({hit_b, hit_a, wrap}),
        .flg_o      (flg),
        .os_o       (os)
    );

    cmt_outlvl u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_a_i (hit_a),
        .hit_b_i (hit_b),
        .os_i    (os),
        .tmr_o   (tmr_out_o),
        .oe_o    (tmr_oe_o)
    );

    always_comb begin
        case (sel_i)
            SEL_CNT:  rdata_o = cnt;
            SEL_CMPA: rdata_o = cmpa;
            SEL_CMPB: rdata_o = cmpb;
            default:  rdata_o = {flg, 1'b1, os};
        endcase
    end
endmodule

// File: tb/cmt_timer_test.sv
module cmt_timer_test;
    localparam int CLK_PERIOD = 10;

    // {action bits, level after match from 0, level after match from 1}
    localparam logic [5:0] VEC [16] = '{
        6'b0000_00, 6'b0001_00, 6'b0010_11, 6'b0011_10,
        6'b0100_00, 6'b0101_00, 6'b0110_11, 6'b0111_10,
        6'b1000_11, 6'b1001_11, 6'b1010_11, 6'b1011_10,
        6'b1100_10, 6'b1101_10, 6'b1110_10, 6'b1111_10
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [1:0] sel_i = 2'd0;
    logic       rd_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       tmr_out_o, tmr_oe_o;
    int         nchk = 0;
    int         nbad = 0;

    cmt_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .sel_i     (sel_i),
        .rd_i      (rd_i),
        .wr_i      (wr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .tmr_out_o (tmr_out_o),
        .tmr_oe_o  (tmr_oe_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
        sel_i = s; wdata_i = d; wr_i = 1'b1;
        @(posedge clk); #1;
        wr_i = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] s);
        sel_i = s; rd_i = 1'b1;
        @(posedge clk); #1;
        rd_i = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [7:0] d);
        sel_i = s; #1;
        d = rdata_o;
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            tick_i = 1'b1;
            @(posedge clk); #1;
            tick_i = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        peek(2'd3, v); check("R1 status", v, 8'h10);
        peek(2'd0, v); check("R1 counter", v, 8'h00);
        peek(2'd1, v); check("R1 compare A", v, 8'h00);
        check("R1 out/oe", {6'b0, tmr_out_o, tmr_oe_o}, 8'h00);

        // R7 and R5: reserved bit, write-one never sets
        wr_reg(2'd3, 8'hEF);
        peek(2'd3, v); check("R7 R5 write ones", v, 8'h1F);
        wr_reg(2'd3, 8'h00);
        peek(2'd3, v); check("R7 bit4 held", v, 8'h10);

        // R10, R8, R3: compare A invert action
        wr_reg(2'd1, 8'h05);
        wr_reg(2'd3, 8'h03);
        check("R10 oe", {7'b0, tmr_oe_o}, 8'h01);
        tick(3);
        check("R10 low before match", {7'b0, tmr_out_o}, 8'h00);
        tick(2);
        peek(2'd0, v); check("R2 count", v, 8'h05);
        check("R8 invert on A", {7'b0, tmr_out_o}, 8'h01);
        peek(2'd3, v); check("R3 flag A", v, 8'h53);

        // R3: compare write equal to counter raises nothing
        wr_reg(2'd2, 8'h05);
        peek(2'd3, v); check("R3 no flag on compare write", v, 8'h53);

        // R5: clearing sequence
        wr_reg(2'd3, 8'h03);
        peek(2'd3, v); check("R5 write0 without read", v, 8'h53);
        rd_reg(2'd3);
        wr_reg(2'd3, 8'h03);
        peek(2'd3, v); check("R5 read then write0", v, 8'h13);

        // R2, R4: wrap and overflow flag
        wr_reg(2'd0, 8'hFE);
        tick(2);
        peek(2'd0, v); check("R2 wrap", v, 8'h00);
        peek(2'd3, v); check("R4 overflow flag", v, 8'h33);
        check("R8 no match keeps level", {7'b0, tmr_out_o}, 8'h01);

        // R2: write beats tick
        sel_i = 2'd0; wdata_i = 8'h40; wr_i = 1'b1; tick_i = 1'b1;
        @(posedge clk); #1;
        wr_i = 1'b0; tick_i = 1'b0;
        peek(2'd0, v); check("R2 write over tick", v, 8'h40);

        // R6: hardware set beats clearing write
        wr_reg(2'd0, 8'h04);
        tick(1);
        rd_reg(2'd3);
        wr_reg(2'd0, 8'h04);
        sel_i = 2'd3; wdata_i = 8'h03; wr_i = 1'b1; tick_i = 1'b1;
        @(posedge clk); #1;
        wr_i = 1'b0; tick_i = 1'b0;
        peek(2'd3, v); check("R6 set wins over clear", v, 8'hD3);
        wr_reg(2'd3, 8'h03);
        peek(2'd3, v); check("R5 pending read consumed", v, 8'hD3);

        // R9 / R8 / R10: every action pair from both levels
        wr_reg(2'd1, 8'h20);
        wr_reg(2'd2, 8'h20);
        for (int i = 0; i < 16; i++) begin
            for (int s = 0; s < 2; s++) begin
                wr_reg(2'd0, 8'h1F);
                wr_reg(2'd3, (s == 1) ? 8'h0A : 8'h05);
                tick(1);
                wr_reg(2'd0, 8'h1F);
                wr_reg(2'd3, {4'h0, VEC[i][5:2]});
                tick(1);
                check($sformatf("R9 pair os=%0h from %0d", VEC[i][5:2], s),
                      {7'b0, tmr_out_o}, {7'b0, (s == 1) ? VEC[i][0] : VEC[i][1]});
                check("R10 enable", {7'b0, tmr_oe_o}, {7'b0, |VEC[i][5:2]});
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end
endmodule